// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a virtual byte address into a physical address for loads and stores of one, two or four bytes. It holds two sets of translation entries. One is a small fully associative buffer. The other is a linear page table indexed by virtual page number, with a programmable length. A static mode input chooses which set is consulted. Both sets are loaded through one entry write port while no request is in flight.

A request strobe presents the address, the size code and the direction. One cycle later the block raises `done` with either a physical address or a single exception code. The checks follow a fixed priority: alignment first, then page-table range or lookup validity, then write protection, then the physical frame bound. A successful access marks its entry as used. A successful store also marks it as dirty. Those flags can be read back through a combinational read port.

Top module: `addr_xlate`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle with `req` high, and is low otherwise. `exc` and `pa` keep their value until the next request.
- R2: Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. A four-byte access with `req_addr[1:0]` nonzero, or a two-byte access with `req_addr[0]` set, yields exception code 1 (address error) whatever the entries hold.
- R3: In page-table mode (`mode_buf`=0), a page number (address divided by PAGE_BYTES) that is at or above `pt_len` yields code 1. An in-range entry whose valid bit is clear yields code 2 (page fault).
- R4: In buffer mode (`mode_buf`=1), every valid entry is compared with the page number. Invalid entries never match. If nothing matches, the result is code 2.
- R5: If several valid buffer entries match, the entry with the lowest index is used.
- R6: A store that reaches an entry marked read-only yields code 3. This takes precedence over the frame check, and the entry's use and dirty flags are left unchanged.
- R7: An entry whose frame number is at or above PHYS_PAGES yields code 4 (bus error).
- R8: Otherwise the result is code 0, and `pa` equals the frame times PAGE_BYTES plus the address modulo PAGE_BYTES.
- R9: A code-0 access sets the use flag of the selected entry, and a code-0 store also sets its dirty flag. Any other outcome changes no flag. `rd_use` and `rd_dirty` show the flags of the entry chosen by `rd_buf` and `rd_idx`.
- R10: Reset clears the valid, use and dirty bits of every entry and drives `done` low. Writing an entry replaces its page, frame, valid and read-only fields and clears its use and dirty flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_buf | input | 1 | 1 selects the associative buffer, 0 the page table |
| pt_len | input | PT_IW+1 | Number of page-table entries in use |
| req | input | 1 | Translation request strobe |
| req_addr | input | VA_W | Virtual byte address |
| req_size | input | 2 | Size code: 0 one byte, 1 two bytes, 2 four bytes |
| req_wr | input | 1 | 1 for a store, 0 for a load |
| done | output | 1 | Result valid, one cycle after `req` |
| exc | output | 3 | 0 none, 1 address error, 2 page fault, 3 read-only, 4 bus error |
| pa | output | PA_W | Physical address when `exc` is 0, otherwise 0 |
| wr_en | input | 1 | Entry write strobe |
| wr_buf | input | 1 | 1 writes a buffer entry, 0 a page-table entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | VPN_W | Virtual page tag (used by buffer entries only) |
| wr_frm | input | FRM_W | Physical frame number |
| wr_valid | input | 1 | Valid bit to store |
| wr_ro | input | 1 | Read-only bit to store |
| rd_buf | input | 1 | 1 reads buffer flags, 0 page-table flags |
| rd_idx | input | IDX_W | Entry index for the flag read |
| rd_use | output | 1 | Use flag of the selected entry |
| rd_dirty | output | 1 | Dirty flag of the selected entry |

## Verification
The assertions assume that the entry write strobe is never high in a cycle that carries a request. The stimulus therefore loads every entry before the sweeps begin and only rewrites entries between accesses. They also assume `req_size` is never 3, and the sweeps only use codes 0 to 2. The bench loads a page table whose valid, read-only and frame values follow residues of the page number. It also loads a buffer with duplicated tags and one invalid entry. It then sweeps every page, several offsets, every size and both directions in each mode and at two table lengths. Expected codes, addresses and flag states are computed arithmetically in the bench.

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int VA_W       = 12,
  parameter int PAGE_BYTES = 128,
  parameter int PHYS_PAGES = 12,
  parameter int TLB_DEPTH  = 16,
  parameter int PT_MAX     = 32,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int FRM_W = $clog2(PHYS_PAGES) + 1,
  localparam int PA_W  = $clog2(PHYS_PAGES) + OFF_W,
  localparam int TB_IW = $clog2(TLB_DEPTH),
  localparam int PT_IW = $clog2(PT_MAX),
  localparam int IDX_W = (TB_IW > PT_IW) ? TB_IW : PT_IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_buf,
  input  logic [PT_IW:0]   pt_len,
  input  logic             req,
  input  logic [VA_W-1:0]  req_addr,
  input  logic [1:0]       req_size,
  input  logic             req_wr,
  output logic             done,
  output logic [2:0]       exc,
  output logic [PA_W-1:0]  pa,
  input  logic             wr_en,
  input  logic             wr_buf,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [FRM_W-1:0] wr_frm,
  input  logic             wr_valid,
  input  logic             wr_ro,
  input  logic             rd_buf,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_use,
  output logic             rd_dirty
);
  logic [VPN_W-1:0] b_vpn [TLB_DEPTH];
  logic [FRM_W-1:0] b_frm [TLB_DEPTH];
  logic [TLB_DEPTH-1:0] b_v, b_ro, b_use, b_dty, hit_vec;
  logic [FRM_W-1:0] t_frm [PT_MAX];
  logic [PT_MAX-1:0] t_v, t_ro, t_use, t_dty;

  wire [VPN_W-1:0] vpn    = req_addr[VA_W-1:OFF_W];
  wire [PT_IW-1:0] pt_idx = PT_IW'(vpn);
  wire [TB_IW-1:0] wb_idx = TB_IW'(wr_idx);
  wire [PT_IW-1:0] wt_idx = PT_IW'(wr_idx);

  wire misal = (req_size == 2'd2 && req_addr[1:0] != 2'b00) ||
               (req_size == 2'd1 && req_addr[0]);
  wire in_range = (32'(vpn) < 32'(pt_len)) && (32'(vpn) < PT_MAX);

  for (genvar i = 0; i < TLB_DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = b_v[i] && (b_vpn[i] == vpn);
  end

  logic [TB_IW-1:0] hit_idx;
  always_comb begin
    hit_idx = '0;
    for (int i = TLB_DEPTH - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = TB_IW'(i);
  end

  wire             sel_v   = mode_buf ? |hit_vec        : t_v[pt_idx];
  wire             sel_ro  = mode_buf ? b_ro[hit_idx]   : t_ro[pt_idx];
  wire [FRM_W-1:0] sel_frm = mode_buf ? b_frm[hit_idx]  : t_frm[pt_idx];

  logic [2:0] nxt_exc;
  always_comb begin
    if (misal)                            nxt_exc = 3'd1;
    else if (!mode_buf && !in_range)      nxt_exc = 3'd1;
    else if (!sel_v)                      nxt_exc = 3'd2;
    else if (sel_ro && req_wr)            nxt_exc = 3'd3;
    else if (32'(sel_frm) >= PHYS_PAGES)  nxt_exc = 3'd4;
    else                                  nxt_exc = 3'd0;
  end
  wire ok = (nxt_exc == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      exc  <= '0;
      pa   <= '0;
      b_v  <= '0; b_use <= '0; b_dty <= '0;
      t_v  <= '0; t_use <= '0; t_dty <= '0;
    end else begin
      done <= req;
      if (req) begin
        exc <= nxt_exc;
        pa  <= ok ? {sel_frm[FRM_W-2:0], req_addr[OFF_W-1:0]} : '0;
        if (ok && mode_buf) begin
          b_use[hit_idx] <= 1'b1;
          if (req_wr) b_dty[hit_idx] <= 1'b1;
        end
        if (ok && !mode_buf) begin
          t_use[pt_idx] <= 1'b1;
          if (req_wr) t_dty[pt_idx] <= 1'b1;
        end
      end
      if (wr_en && wr_buf) begin
        b_v[wb_idx] <= wr_valid; b_use[wb_idx] <= 1'b0; b_dty[wb_idx] <= 1'b0;
      end
      if (wr_en && !wr_buf) begin
        t_v[wt_idx] <= wr_valid; t_use[wt_idx] <= 1'b0; t_dty[wt_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_buf) begin
      b_vpn[wb_idx] <= wr_vpn;
      b_frm[wb_idx] <= wr_frm;
      b_ro[wb_idx]  <= wr_ro;
    end
    if (wr_en && !wr_buf) begin
      t_frm[wt_idx] <= wr_frm;
      t_ro[wt_idx]  <= wr_ro;
    end
  end

  assign rd_use   = rd_buf ? b_use[TB_IW'(rd_idx)] : t_use[PT_IW'(rd_idx)];
  assign rd_dirty = rd_buf ? b_dty[TB_IW'(rd_idx)] : t_dty[PT_IW'(rd_idx)];

  a_r1_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);
  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done);
  a_r2_word_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_size == 2'd2 && req_addr[1:0] != 2'b00) |=> exc == 3'd1);
  a_r6_ro_only_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc == 3'd3) |-> $past(req_wr));
  a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc == 3'd0) |-> pa[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));
  a_r8_pa_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc == 3'd0) |-> 32'(pa) < PHYS_PAGES * PAGE_BYTES);
  a_r10_no_write_during_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && wr_en));
  a_r2_size_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> req_size != 2'd3);
endmodule

// File: tb/tb_addr_xlate.sv
module tb_addr_xlate;
  localparam int PB = 128, NPP = 12;
  logic clk = 0, rst_n = 0;
  logic mode_buf = 0, req = 0, req_wr = 0;
  logic [5:0] pt_len = '0;
  logic [11:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic done; logic [2:0] exc; logic [10:0] pa;
  logic wr_en = 0, wr_buf = 0, wr_valid = 0, wr_ro = 0, rd_buf = 0;
  logic [4:0] wr_idx = '0, wr_vpn = '0, rd_idx = '0, wr_frm = '0;
  logic rd_use, rd_dirty;

  int checks = 0, errors = 0;
  int m_bvpn[16], m_bfrm[16], m_bv[16], m_bro[16], m_buse[16], m_bdty[16];
  int m_tfrm[32], m_tv[32], m_tro[32], m_tuse[32], m_tdty[32];

  always #5 clk = ~clk;

  addr_xlate dut (.clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .pt_len(pt_len),
    .req(req), .req_addr(req_addr), .req_size(req_size), .req_wr(req_wr),
    .done(done), .exc(exc), .pa(pa), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_frm(wr_frm), .wr_valid(wr_valid),
    .wr_ro(wr_ro), .rd_buf(rd_buf), .rd_idx(rd_idx), .rd_use(rd_use),
    .rd_dirty(rd_dirty));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input int buf_sel, input int idx, input int vpn,
                     input int frm, input int v, input int ro);
    @(negedge clk);
    wr_en = 1; wr_buf = buf_sel[0]; wr_idx = 5'(idx); wr_vpn = 5'(vpn);
    wr_frm = 5'(frm); wr_valid = v[0]; wr_ro = ro[0];
    @(negedge clk);
    wr_en = 0;
    if (buf_sel != 0) begin
      m_bvpn[idx] = vpn; m_bfrm[idx] = frm; m_bv[idx] = v; m_bro[idx] = ro;
      m_buse[idx] = 0; m_bdty[idx] = 0;
    end else begin
      m_tfrm[idx] = frm; m_tv[idx] = v; m_tro[idx] = ro;
      m_tuse[idx] = 0; m_tdty[idx] = 0;
    end
  endtask

  task automatic access(input int addr, input int sz, input int wr);
    int vpn, off, e, frm, hit, code, exp_pa;
    string tag;
    vpn = addr / PB; off = addr % PB; e = -1; frm = 0; code = 0;
    if ((sz == 2 && addr % 4 != 0) || (sz == 1 && addr % 2 != 0)) begin
      code = 1; tag = "R2";
    end else if (!mode_buf) begin
      tag = "R3";
      if (vpn >= int'(pt_len)) code = 1;
      else if (m_tv[vpn] == 0) code = 2;
      else e = vpn;
    end else begin
      hit = -1;
      for (int i = 15; i >= 0; i--) if (m_bv[i] != 0 && m_bvpn[i] == vpn) hit = i;
      tag = "R4/R5";
      if (hit < 0) code = 2; else e = hit;
    end
    if (e >= 0) begin
      frm = mode_buf ? m_bfrm[e] : m_tfrm[e];
      if ((mode_buf ? m_bro[e] : m_tro[e]) != 0 && wr != 0) begin code = 3; tag = "R6"; end
      else if (frm >= NPP) begin code = 4; tag = "R7"; end
      else begin
        tag = "R8";
        if (mode_buf) begin m_buse[e] = 1; if (wr != 0) m_bdty[e] = 1; end
        else begin m_tuse[e] = 1; if (wr != 0) m_tdty[e] = 1; end
      end
    end
    exp_pa = (code == 0) ? frm * PB + off : 0;
    @(negedge clk);
    req = 1; req_addr = 12'(addr); req_size = 2'(sz); req_wr = wr[0];
    @(negedge clk);
    req = 0;
    check({tag, " exc"}, int'(exc), code);
    check({tag, " pa"}, int'(pa), exp_pa);
    check("R1 done", int'(done), 1);
  endtask

  task automatic flags_all();
    for (int i = 0; i < 32; i++) begin
      rd_buf = 0; rd_idx = 5'(i); #1;
      check("R9 table use", int'(rd_use), m_tuse[i]);
      check("R9 table dirty", int'(rd_dirty), m_tdty[i]);
    end
    for (int i = 0; i < 16; i++) begin
      rd_buf = 1; rd_idx = 5'(i); #1;
      check("R9 buffer use", int'(rd_use), m_buse[i]);
      check("R9 buffer dirty", int'(rd_dirty), m_bdty[i]);
    end
  endtask

  task automatic sweep();
    int offs[5] = '{0, 1, 2, 6, 127};
    for (int v = 0; v < 32; v++)
      for (int o = 0; o < 5; o++)
        for (int s = 0; s < 3; s++)
          for (int w = 0; w < 2; w++)
            access(v * PB + offs[o], s, w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset done", int'(done), 0);
    for (int i = 0; i < 32; i++) begin
      rd_buf = 0; rd_idx = 5'(i); #1;
      check("R10 reset table flags", int'(rd_use) + int'(rd_dirty), 0);
    end
    rst_n = 1;
    for (int v = 0; v < 32; v++)
      put(0, v, 0, v % 14, (v % 5) != 4, (v % 3) == 1);
    for (int i = 0; i < 16; i++)
      put(1, i, (i % 12) + 10, (i * 3) % 14, i != 5, (i % 4) == 3);
    flags_all();
    mode_buf = 0; pt_len = 6'd20; sweep(); flags_all();
    @(negedge clk);
    check("R1 done low after result", int'(done), 0);
    pt_len = 6'd32; sweep(); flags_all();
    mode_buf = 1; sweep(); flags_all();
    put(0, 3, 0, 2, 1, 0);
    put(1, 0, 10, 0, 1, 0);
    rd_buf = 0; rd_idx = 5'd3; #1;
    check("R10 rewrite table use", int'(rd_use), 0);
    rd_buf = 1; rd_idx = 5'd0; #1;
    check("R10 rewrite buffer use", int'(rd_use), 0);
    access(10 * PB + 4, 2, 1);
    flags_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule